// File: doc/BRIEF.md
# Three-Wire Synthesizer Configuration Loader

This block takes configuration words from a three-wire serial port (shift clock, data, latch strobe) and turns them into the working registers of a fractional-N main loop, an auxiliary loop, a reference divider and a set of mode and power-enable bits. Words are 24 bits long and are shifted in MSB first while the strobe is low. When the strobe goes high, an address field at the top of the word picks the target register set, and the payload is transferred into it.

Two register groups are loaded in a deferred way. The fractional compensation DAC value from the B word waits in a temporary register. The main-loop word (A word) waits in a pending holder until the main divider reports terminal count. At that terminal-count pulse the pending A word and the staged DAC value enter the working registers together, so the loop never sees a mixed old and new setting. If the strobe is still high at that moment, a speed-up flag for the charge pump rises. It stays up until the strobe falls. Power-enable bits are only driven out and switch nothing inside the block.

All serial inputs are sampled by the system clock `clk`, which is assumed to be much faster than the serial clock. The reset is synchronous and active high.

Top module: `ser3w_loader`

## Requirements
- R1: On a `clk` edge where `ser_clk` is high, `ser_clk` was low at the previous edge and `ser_strobe` is low, the 24-bit shift register shifts left and takes `ser_data` into bit 0. Bit 23 is therefore the first bit sent. While `ser_strobe` is high, `ser_clk` edges leave the shift register unchanged.
- R2: Address decode uses the top bits of the word. Bits[23:22]=00 selects the A word, 01 the B word and 10 the C word. Bits[23:21]=110 selects the D word. Bits[23:21]=111 loads nothing.
- R3: The first `clk` edge that sees `ser_strobe` high after it was low performs the load. B fields are fdac=[21:14] (staged), ref_div=[13:4], ref_sel_main=[3:2] and ref_sel_aux=[1:0]. C fields are aux_div=[21:8], lock_sel=[7:6], pwr_main=[5] and pwr_aux=[4]. D fields are pwr_ctrl=[20:13], offset_msel=[12:11], offset_en=[10], tx_mode=[9], dig_mode=[8], lo_buf_en=[7] and rclk_buf_en=[6]. The B reference fields and all C and D fields appear on the outputs one edge after the load.
- R4: `main_fdac` changes only when an A word commits. It then takes the most recently staged B-word DAC value.
- R5: A loaded A word (fmod=[21], nf=[20:18], nmain=[17:2], cp=[1:0]) raises `a_pending`. It is copied to the main outputs at the first later `clk` edge with `div_tc` high, whatever the level of `ser_strobe`. `a_pending` falls at that same edge.
- R6: `speedup` rises at an A-word commit edge when `ser_strobe` is high. It stays high while `ser_strobe` stays high and is low one edge after `ser_strobe` is sampled low. A commit with the strobe low leaves `speedup` low.
- R7: One strobe-high interval causes at most one load, however long it lasts.
- R8: After reset, every register output, `a_pending` and `speedup` are 0. This means power-enables off, tx_mode 0 (dual mode) and offset loop off.
- R9: A `div_tc` pulse on the same edge as an A-word load does not commit that word. A second A word loaded while one is pending replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_strobe | input | 1 | Latch strobe; low = shift, rising = load |
| div_tc | input | 1 | Main divider terminal-count pulse |
| main_fmod | output | 1 | Fractional modulus select |
| main_nf | output | 3 | Fractional increment |
| main_nmain | output | 16 | Main divider ratio |
| main_cp | output | 2 | Charge-pump current ratio |
| main_fdac | output | 8 | Fractional compensation DAC |
| ref_div | output | 10 | Reference divider ratio |
| ref_sel_main | output | 2 | Main reference phase select |
| ref_sel_aux | output | 2 | Auxiliary reference phase select |
| aux_div | output | 14 | Auxiliary divider ratio |
| lock_sel | output | 2 | Lock indicator source select |
| pwr_main | output | 1 | Main loop power enable |
| pwr_aux | output | 1 | Auxiliary loop power enable |
| pwr_ctrl | output | 8 | Transmit output attenuation code |
| offset_msel | output | 2 | Offset loop divide-by select |
| offset_en | output | 1 | Offset synthesizer enable |
| tx_mode | output | 1 | Transmit mode select (0 = dual) |
| dig_mode | output | 1 | Digital/analog mode select |
| lo_buf_en | output | 1 | Transmit LO buffer enable |
| rclk_buf_en | output | 1 | Secondary clock buffer enable |
| speedup | output | 1 | Charge-pump speed-up flag |
| a_pending | output | 1 | A word waiting for terminal count |

## Verification
Random words of all five address classes are sent, with the terminal-count pulse placed at random either inside the strobe-high window or after it. This separates correct address decoding and field placement from swapped or shifted fields, and separates an in-window commit (speed-up high) from a late commit (speed-up low). Directed sequences cover further cases. Serial clock pulses during strobe high are followed by a strobe re-pulse, which exposes any shift that should have been blocked. A long strobe-high window with repeated terminal-count pulses exposes a missing one-shot. A B word without a following A word must leave the DAC output untouched. A terminal-count pulse on the load edge itself must not commit the word.

// File: rtl/ser3w_pkg.sv
package ser3w_pkg;
  parameter int WORD_W    = 24;
  parameter int ADDR_W    = 2;
  parameter int ADDR_X_W  = 3;
  parameter int PAY_W     = WORD_W - ADDR_W;
  parameter int NMAIN_W   = 16;
  parameter int NF_W      = 3;
  parameter int CP_W      = 2;
  parameter int FDAC_W    = 8;
  parameter int NREF_W    = 10;
  parameter int RSEL_W    = 2;
  parameter int NAUX_W    = 14;
  parameter int LDS_W     = 2;
  parameter int PC_W      = 8;
  parameter int MSEL_W    = 2;

  localparam logic [ADDR_W-1:0]   ADDR_A = 2'b00;
  localparam logic [ADDR_W-1:0]   ADDR_B = 2'b01;
  localparam logic [ADDR_W-1:0]   ADDR_C = 2'b10;
  localparam logic [ADDR_X_W-1:0] ADDR_D = 3'b110;

  typedef struct packed {
    logic a;
    logic b;
    logic c;
    logic d;
  } load_vec_t;

  typedef struct packed {
    logic               fmod;
    logic [NF_W-1:0]    nf;
    logic [NMAIN_W-1:0] nmain;
    logic [CP_W-1:0]    cp;
  } a_word_t;

  typedef struct packed {
    logic [FDAC_W-1:0] fdac;
    logic [NREF_W-1:0] nref;
    logic [RSEL_W-1:0] rsel_main;
    logic [RSEL_W-1:0] rsel_aux;
  } b_word_t;

  typedef struct packed {
    logic [NAUX_W-1:0] naux;
    logic [LDS_W-1:0]  lock_sel;
    logic              pwr_main;
    logic              pwr_aux;
    logic [3:0]        spare;
  } c_word_t;

  typedef struct packed {
    logic [PC_W-1:0]   pc;
    logic [MSEL_W-1:0] msel;
    logic              offset_en;
    logic              tx_mode;
    logic              dig_mode;
    logic              lo_buf_en;
    logic              rclk_buf_en;
    logic [5:0]        spare;
  } d_word_t;
endpackage

// File: rtl/ser3w_shifter.sv
module ser3w_shifter #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_strobe,
  output logic [WORD_W-1:0] shreg
);
  logic sclk_q;
  logic shift_en;

  assign shift_en = ser_clk & ~sclk_q & ~ser_strobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      shreg  <= '0;
    end else begin
      sclk_q <= ser_clk;
      if (shift_en) shreg <= {shreg[WORD_W-2:0], ser_data};
    end
  end

  // R1: a high strobe freezes the shift register
  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    ser_strobe |=> $stable(shreg));
endmodule

// File: rtl/ser3w_load_ctrl.sv
module ser3w_load_ctrl
  import ser3w_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ser_strobe,
  input  logic [W-1:0] shreg,
  output load_vec_t    ld
);
  logic armed;
  logic fire;
  logic [ADDR_W-1:0]   addr2;
  logic [ADDR_X_W-1:0] addr3;

  assign fire  = ser_strobe & armed;
  assign addr2 = shreg[W-1 -: ADDR_W];
  assign addr3 = shreg[W-1 -: ADDR_X_W];

  // one-shot: re-armed only by a low strobe, spent by the first high cycle
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= ~ser_strobe;
  end

  always_comb begin
    ld   = '0;
    ld.a = fire && (addr2 == ADDR_A);
    ld.b = fire && (addr2 == ADDR_B);
    ld.c = fire && (addr2 == ADDR_C);
    ld.d = fire && (addr3 == ADDR_D);
  end

  // R2: at most one target per load
  assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ld));
  // R7: a load is never followed directly by another
  assert_one_load_R7: assert property (@(posedge clk) disable iff (rst)
    (ld != '0) |=> (ld == '0));
endmodule

// File: rtl/ser3w_reg_bank.sv
module ser3w_reg_bank
  import ser3w_pkg::*;
#(
  parameter int PW = PAY_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ser_strobe,
  input  logic          div_tc,
  input  load_vec_t     ld,
  input  logic [PW-1:0] payload,
  output a_word_t       a_work,
  output logic [FDAC_W-1:0] fdac_work,
  output b_word_t       b_work,
  output c_word_t       c_work,
  output d_word_t       d_work,
  output logic          speedup,
  output logic          pend
);
  a_word_t           a_pend;
  logic [FDAC_W-1:0] fdac_tmp;
  logic              commit;
  b_word_t           b_in;

  assign commit = pend & div_tc;
  assign b_in   = b_word_t'(payload);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_pend    <= '0;
      a_work    <= '0;
      fdac_tmp  <= '0;
      fdac_work <= '0;
      b_work    <= '0;
      c_work    <= '0;
      d_work    <= '0;
      pend      <= 1'b0;
      speedup   <= 1'b0;
    end else begin
      if (ld.a) a_pend <= a_word_t'(payload);
      if (ld.b) begin
        fdac_tmp <= b_in.fdac;
        b_work   <= b_in;
      end
      if (ld.c) c_work <= c_word_t'(payload);
      if (ld.d) d_work <= d_word_t'(payload[PW-2:0]);
      if (commit) begin
        a_work    <= a_pend;
        fdac_work <= fdac_tmp;
      end
      pend    <= ld.a | (pend & ~div_tc);
      speedup <= ser_strobe & (speedup | commit);
    end
  end

  // R4: the DAC output moves only on a commit
  assert_fdac_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(pend && div_tc) |=> $stable(fdac_work));
  // R5: a terminal count retires the pending word unless a new one arrives
  assert_commit_R5: assert property (@(posedge clk) disable iff (rst)
    (pend && div_tc && !ld.a) |=> !pend);
  // R6: speed-up never outlives the strobe
  assert_speedup_drop_R6: assert property (@(posedge clk) disable iff (rst)
    !ser_strobe |=> !speedup);
endmodule

// File: rtl/ser3w_loader.sv
module ser3w_loader
  import ser3w_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               ser_clk,
  input  logic               ser_data,
  input  logic               ser_strobe,
  input  logic               div_tc,
  output logic               main_fmod,
  output logic [NF_W-1:0]    main_nf,
  output logic [NMAIN_W-1:0] main_nmain,
  output logic [CP_W-1:0]    main_cp,
  output logic [FDAC_W-1:0]  main_fdac,
  output logic [NREF_W-1:0]  ref_div,
  output logic [RSEL_W-1:0]  ref_sel_main,
  output logic [RSEL_W-1:0]  ref_sel_aux,
  output logic [NAUX_W-1:0]  aux_div,
  output logic [LDS_W-1:0]   lock_sel,
  output logic               pwr_main,
  output logic               pwr_aux,
  output logic [PC_W-1:0]    pwr_ctrl,
  output logic [MSEL_W-1:0]  offset_msel,
  output logic               offset_en,
  output logic               tx_mode,
  output logic               dig_mode,
  output logic               lo_buf_en,
  output logic               rclk_buf_en,
  output logic               speedup,
  output logic               a_pending
);
  logic [WORD_W-1:0] shreg;
  load_vec_t         ld;
  a_word_t           a_work;
  b_word_t           b_work;
  c_word_t           c_work;
  d_word_t           d_work;

  ser3w_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_strobe(ser_strobe), .shreg(shreg)
  );

  ser3w_load_ctrl #(.W(WORD_W)) u_ctrl (
    .clk(clk), .rst(rst), .ser_strobe(ser_strobe), .shreg(shreg), .ld(ld)
  );

  ser3w_reg_bank #(.PW(PAY_W)) u_regs (
    .clk(clk), .rst(rst), .ser_strobe(ser_strobe), .div_tc(div_tc),
    .ld(ld), .payload(shreg[PAY_W-1:0]),
    .a_work(a_work), .fdac_work(main_fdac), .b_work(b_work),
    .c_work(c_work), .d_work(d_work), .speedup(speedup), .pend(a_pending)
  );

  assign main_fmod    = a_work.fmod;
  assign main_nf      = a_work.nf;
  assign main_nmain   = a_work.nmain;
  assign main_cp      = a_work.cp;
  assign ref_div      = b_work.nref;
  assign ref_sel_main = b_work.rsel_main;
  assign ref_sel_aux  = b_work.rsel_aux;
  assign aux_div      = c_work.naux;
  assign lock_sel     = c_work.lock_sel;
  assign pwr_main     = c_work.pwr_main;
  assign pwr_aux      = c_work.pwr_aux;
  assign pwr_ctrl     = d_work.pc;
  assign offset_msel  = d_work.msel;
  assign offset_en    = d_work.offset_en;
  assign tx_mode      = d_work.tx_mode;
  assign dig_mode     = d_work.dig_mode;
  assign lo_buf_en    = d_work.lo_buf_en;
  assign rclk_buf_en  = d_work.rclk_buf_en;
endmodule

// File: tb/ser3w_loader_tb_top.sv
`timescale 1ns/1ps
module ser3w_loader_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_strobe = 1'b0, div_tc = 1'b0;

  logic        main_fmod;
  logic [2:0]  main_nf;
  logic [15:0] main_nmain;
  logic [1:0]  main_cp;
  logic [7:0]  main_fdac;
  logic [9:0]  ref_div;
  logic [1:0]  ref_sel_main, ref_sel_aux;
  logic [13:0] aux_div;
  logic [1:0]  lock_sel;
  logic        pwr_main, pwr_aux;
  logic [7:0]  pwr_ctrl;
  logic [1:0]  offset_msel;
  logic        offset_en, tx_mode, dig_mode, lo_buf_en, rclk_buf_en;
  logic        speedup, a_pending;

  always #10 clk = ~clk;

  ser3w_loader dut_i (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_strobe(ser_strobe), .div_tc(div_tc),
    .main_fmod(main_fmod), .main_nf(main_nf), .main_nmain(main_nmain),
    .main_cp(main_cp), .main_fdac(main_fdac), .ref_div(ref_div),
    .ref_sel_main(ref_sel_main), .ref_sel_aux(ref_sel_aux),
    .aux_div(aux_div), .lock_sel(lock_sel), .pwr_main(pwr_main),
    .pwr_aux(pwr_aux), .pwr_ctrl(pwr_ctrl), .offset_msel(offset_msel),
    .offset_en(offset_en), .tx_mode(tx_mode), .dig_mode(dig_mode),
    .lo_buf_en(lo_buf_en), .rclk_buf_en(rclk_buf_en),
    .speedup(speedup), .a_pending(a_pending)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;

  // bench model, built from the requirement text
  logic [21:0] e_apend, e_awork;
  logic [7:0]  e_ftmp, e_fdac;
  logic [9:0]  e_nref;
  logic [1:0]  e_rsm, e_rsa, e_lds, e_msel;
  logic [13:0] e_naux;
  logic        e_pm, e_pa, e_se, e_tm, e_ad, e_sm1, e_sm2, e_pend, e_spd;
  logic [7:0]  e_pc;

  wire [76:0] act_obs = {main_fmod, main_nf, main_nmain, main_cp, main_fdac,
                         ref_div, ref_sel_main, ref_sel_aux, aux_div, lock_sel,
                         pwr_main, pwr_aux, pwr_ctrl, offset_msel, offset_en,
                         tx_mode, dig_mode, lo_buf_en, rclk_buf_en};

  function automatic logic [76:0] exp_obs();
    return {e_awork, e_fdac, e_nref, e_rsm, e_rsa, e_naux, e_lds, e_pm, e_pa,
            e_pc, e_msel, e_se, e_tm, e_ad, e_sm1, e_sm2};
  endfunction

  task automatic model_reset();
    e_apend = '0; e_awork = '0; e_ftmp = '0; e_fdac = '0; e_nref = '0;
    e_rsm = '0; e_rsa = '0; e_naux = '0; e_lds = '0; e_pm = 0; e_pa = 0;
    e_pc = '0; e_msel = '0; e_se = 0; e_tm = 0; e_ad = 0; e_sm1 = 0; e_sm2 = 0;
    e_pend = 0; e_spd = 0;
  endtask

  task automatic model_load(input logic [23:0] w);
    case (w[23:22])
      2'b00: begin e_apend = w[21:0]; e_pend = 1; end
      2'b01: begin e_ftmp = w[21:14]; e_nref = w[13:4]; e_rsm = w[3:2]; e_rsa = w[1:0]; end
      2'b10: begin e_naux = w[21:8]; e_lds = w[7:6]; e_pm = w[5]; e_pa = w[4]; end
      default: if (!w[21]) begin
        e_pc = w[20:13]; e_msel = w[12:11]; e_se = w[10]; e_tm = w[9];
        e_ad = w[8]; e_sm1 = w[7]; e_sm2 = w[6];
      end
    endcase
  endtask

  task automatic model_commit(input logic strobe_now);
    if (e_pend) begin
      e_awork = e_apend; e_fdac = e_ftmp; e_pend = 0; e_spd = strobe_now;
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk_obs(input string req);
    tests++;
    if (act_obs !== exp_obs()) begin
      fails++;
      $display("FAIL %s regs act=%h exp=%h", req, act_obs, exp_obs());
    end
  endtask

  task automatic chk_bit(input string req, input string nm, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%b exp=%b", req, nm, act, exp);
    end
  endtask

  task automatic shift_word(input logic [23:0] w);
    for (int b = 23; b >= 0; b--) begin
      ser_data = w[b]; ser_clk = 0; tick(); tick();
      ser_clk = 1; tick(); tick();
    end
    ser_clk = 0; tick();
  endtask

  task automatic strobe_up(input logic [23:0] w);
    ser_strobe = 1; tick(); model_load(w);
  endtask

  task automatic pulse_tc();
    div_tc = 1; tick(); div_tc = 0; model_commit(ser_strobe);
  endtask

  task automatic strobe_down();
    ser_strobe = 0; tick(); e_spd = 0;
  endtask

  task automatic send(input logic [23:0] w);
    shift_word(w); strobe_up(w);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] w, y;
    int unsigned seed;
    model_reset();
    repeat (3) tick();
    rst = 0; tick();
    // R8: reset state
    chk_obs("R8"); chk_bit("R8", "a_pending", a_pending, 0);
    chk_bit("R8", "speedup", speedup, 0);

    // R3: C and D loads one edge after the strobe rises
    send({2'b10, 14'h2AC5, 2'b10, 1'b1, 1'b0, 4'h0}); chk_obs("R3"); strobe_down();
    send({3'b110, 8'hA7, 2'b01, 5'b10110, 6'h0}); chk_obs("R3"); strobe_down();

    // R4: B stages DAC; main_fdac untouched until A commits
    send({2'b01, 8'h5C, 10'h1F3, 2'b10, 2'b01}); strobe_down(); pulse_tc();
    chk_obs("R4");
    // R5 / R6: A commits inside strobe-high window, speed-up follows strobe
    send({2'b00, 1'b1, 3'd5, 16'hBEEF, 2'b11});
    chk_bit("R5", "a_pending", a_pending, 1); chk_obs("R5");
    pulse_tc(); chk_obs("R4"); chk_bit("R6", "speedup", speedup, 1);
    // R7: long strobe-high window, more terminal counts, no second load
    repeat (4) tick(); pulse_tc();
    chk_bit("R7", "a_pending", a_pending, 0); chk_bit("R6", "speedup", speedup, 1);
    strobe_down(); chk_bit("R6", "speedup", speedup, 0);

    // R5: late commit after strobe fell, speed-up stays low
    send({2'b00, 1'b0, 3'd2, 16'h0200, 2'b01}); strobe_down();
    chk_bit("R5", "a_pending", a_pending, 1); chk_obs("R5");
    repeat (3) tick(); pulse_tc();
    chk_obs("R5"); chk_bit("R6", "speedup", speedup, 0);

    // R9: terminal count on the load edge does not commit; replacement
    shift_word({2'b00, 1'b1, 3'd7, 16'h1234, 2'b00});
    ser_strobe = 1; div_tc = 1; tick(); div_tc = 0;
    model_load({2'b00, 1'b1, 3'd7, 16'h1234, 2'b00});
    chk_bit("R9", "a_pending", a_pending, 1); chk_obs("R9"); strobe_down();
    send({2'b00, 1'b0, 3'd1, 16'hCAFE, 2'b10}); strobe_down(); pulse_tc();
    chk_obs("R9");

    // R2: address 111 loads nothing
    send({3'b111, 21'h1FFFFF}); chk_obs("R2"); strobe_down();

    // R1: serial clocks during strobe high must not shift
    y = {3'b110, 8'b10011010, 2'b11, 5'b01011, 6'h15};
    send(y); strobe_down();
    ser_strobe = 1; tick();
    for (int k = 0; k < 3; k++) begin
      ser_data = 1; ser_clk = 1; tick(); ser_clk = 0; tick();
    end
    strobe_down(); ser_strobe = 1; tick(); model_load(y);
    chk_obs("R1"); strobe_down();

    // random mix
    seed = 32'h5EED1234;
    void'($urandom(seed));
    for (int i = 0; i < 40; i++) begin
      int kind;
      logic [23:0] p;
      kind = $urandom_range(0, 4);
      p = 24'($urandom);
      case (kind)
        0: w = {2'b00, p[21:0]};
        1: w = {2'b01, p[21:0]};
        2: w = {2'b10, p[21:0]};
        3: w = {3'b110, p[20:0]};
        default: w = {3'b111, p[20:0]};
      endcase
      send(w); chk_obs("R2"); chk_bit("R5", "a_pending", a_pending, e_pend);
      if ($urandom_range(0, 1) == 1) begin
        pulse_tc(); chk_bit("R6", "speedup", speedup, e_spd);
      end
      strobe_down(); chk_bit("R6", "speedup", speedup, 0);
      if ($urandom_range(0, 1) == 1) pulse_tc();
      chk_obs("R3");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule